// File: doc/BRIEF.md
# Phase-Frequency Detector with Charge-Pump Control

This block compares two divided clocks, a reference divider pulse and a feedback divider pulse, and produces the pump-up and pump-down enables that drive a charge pump in a synthesizer loop. Both inputs are synchronous to `clk_i`, and only their rising edges are used. A reference edge latches an up request and a feedback edge latches a down request. Once both requests are held, they are cleared together on the following clock.

Four static controls shape the pump drive:
- A polarity bit matches the detector to the slope of the VCO.
- A high-impedance bit disables the pump output.
- A current bit selects a full-scale or quarter-scale pump current.
- A powerdown bit disables the pump and also holds the detector itself idle.

The block also provides a raw phase-error flag for a lock detector. This flag is independent of polarity and of the output gating.

Top module: `pfd_cp_ctrl`

## Requirements
- R1: After reset the detector holds no request. `up_o`, `dn_o` and `phase_err_o` are 0, and `cp_oe_o` is 1 when `hiz_i` and `pwrdn_i` are 0.
- R2: When `ref_i` is 0 in one cycle and 1 in the next, an up request is latched at the end of that cycle and is visible from the following cycle.
- R3: When `fb_i` is 0 in one cycle and 1 in the next, a down request is latched in the same way.
- R4: In a cycle where both requests are held, both are cleared at the next edge. A new input rising edge in that same cycle is still latched. Simultaneous edges set both requests, and both clear one cycle later.
- R5: A level held high on `ref_i` or `fb_i` latches at most one request, on its first cycle high.
- R6: With `pol_pos_i`=1, the up request drives `up_o` and the down request drives `dn_o`. With `pol_pos_i`=0, the two outputs are swapped.
- R7: While `hiz_i`=1, the outputs are gated:
  - `cp_oe_o` is 0.
  - `up_o`, `dn_o` and `cur_sel_o` are 0.
  - `cur_weight_o` is 0.
  - The detector keeps running.
- R8: While `pwrdn_i`=1, the outputs are gated as in R7. In addition, both requests are cleared at every edge, so `phase_err_o` is 0 from the cycle after powerdown is first seen. After release, the detector restarts from the idle state.
- R9: When the pump is enabled, `cur_sel_o` equals `cur_hi_i`. `cur_weight_o` is `HI_WEIGHT` (default 4) for high current and `HI_WEIGHT/4` (default 1) for low current.
- R10: `phase_err_o` is 1 exactly when one request is held and the other is not, whatever the values of `pol_pos_i` and `hiz_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference divider output |
| fb_i | input | 1 | Feedback divider output |
| pol_pos_i | input | 1 | 1 = positive VCO slope, 0 = negative |
| hiz_i | input | 1 | Force pump output to high impedance |
| cur_hi_i | input | 1 | 1 = full current, 0 = quarter current |
| pwrdn_i | input | 1 | Channel powerdown |
| up_o | output | 1 | Pump-up enable |
| dn_o | output | 1 | Pump-down enable |
| cp_oe_o | output | 1 | Pump output enable (0 = high impedance) |
| cur_sel_o | output | 1 | Current level select to the pump |
| cur_weight_o | output | CUR_W | Relative pump current magnitude |
| phase_err_o | output | 1 | Raw phase-error flag for lock detection |

## Verification
The bench drives several input patterns, and each one separates a different behaviour:
- Reference-first pulses and feedback-first pulses separate the up path from the down path.
- Coincident edges, and an edge landing in a clearing cycle, show whether the clear takes priority over a fresh edge.
- A long-held high level shows whether the detector is edge-triggered or level-triggered.
- Two free-running inputs with periods of 4 and 5 cycles produce a slowly drifting phase that covers every lead and lag.

Each pattern is replayed with:
- negative polarity, to expose any swap error;
- high-Z mode, to show that gating does not touch the detector state;
- powerdown, to show that the state is cleared.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef struct packed {
    logic up;
    logic dn;
  } pump_req_t;

  localparam int unsigned EDGE_CH = 2;
  localparam int unsigned CH_REF  = 0;
  localparam int unsigned CH_FB   = 1;
endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ref_rise_i,
  input  logic      fb_rise_i,
  input  logic      hold_idle_i,
  output pump_req_t req_o
);
  pump_req_t req_q, req_d;
  logic      clr;

  assign clr = req_q.up & req_q.dn;

  always_comb begin
    if (hold_idle_i) begin
      req_d = '0;
    end else begin
      req_d.up = (req_q.up & ~clr) | ref_rise_i;
      req_d.dn = (req_q.dn & ~clr) | fb_rise_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_d;
  end

  assign req_o = req_q;

  assert_joint_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q.up && req_q.dn && !ref_rise_i && !fb_rise_i) |=> (!req_q.up && !req_q.dn));

  assert_pd_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_idle_i |=> (!req_q.up && !req_q.dn));
endmodule

// File: rtl/pfd_out_ctrl.sv
module pfd_out_ctrl
  import pfd_pkg::*;
#(
  parameter int unsigned HI_WEIGHT = 4,
  parameter int unsigned CUR_W     = $clog2(HI_WEIGHT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pump_req_t        req_i,
  input  logic             pol_pos_i,
  input  logic             hiz_i,
  input  logic             pwrdn_i,
  input  logic             cur_hi_i,
  output logic             up_o,
  output logic             dn_o,
  output logic             cp_oe_o,
  output logic             cur_sel_o,
  output logic [CUR_W-1:0] cur_weight_o
);
  localparam int unsigned LO_WEIGHT = HI_WEIGHT / 4;
  localparam logic [CUR_W-1:0] HI_W = CUR_W'(HI_WEIGHT);
  localparam logic [CUR_W-1:0] LO_W = CUR_W'(LO_WEIGHT);

  logic active;
  assign active = ~hiz_i & ~pwrdn_i;

  always_comb begin
    up_o         = 1'b0;
    dn_o         = 1'b0;
    cur_sel_o    = 1'b0;
    cur_weight_o = '0;
    if (active) begin
      up_o         = pol_pos_i ? req_i.up : req_i.dn;
      dn_o         = pol_pos_i ? req_i.dn : req_i.up;
      cur_sel_o    = cur_hi_i;
      cur_weight_o = cur_hi_i ? HI_W : LO_W;
    end
  end

  assign cp_oe_o = active;

  assert_quarter_weight_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_oe_o |-> (cur_weight_o == (cur_sel_o ? HI_W : LO_W)));
endmodule

// File: rtl/pfd_cp_ctrl.sv
module pfd_cp_ctrl
  import pfd_pkg::*;
#(
  parameter int unsigned HI_WEIGHT = 4,
  localparam int unsigned CUR_W    = $clog2(HI_WEIGHT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic             fb_i,
  input  logic             pol_pos_i,
  input  logic             hiz_i,
  input  logic             cur_hi_i,
  input  logic             pwrdn_i,
  output logic             up_o,
  output logic             dn_o,
  output logic             cp_oe_o,
  output logic             cur_sel_o,
  output logic [CUR_W-1:0] cur_weight_o,
  output logic             phase_err_o
);
  logic [EDGE_CH-1:0] rise;
  pump_req_t          req;

  pfd_edge_det #(.N(EDGE_CH)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({fb_i, ref_i}),
    .rise_o (rise)
  );

  pfd_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_rise_i  (rise[CH_REF]),
    .fb_rise_i   (rise[CH_FB]),
    .hold_idle_i (pwrdn_i),
    .req_o       (req)
  );

  pfd_out_ctrl #(.HI_WEIGHT(HI_WEIGHT), .CUR_W(CUR_W)) u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req),
    .pol_pos_i    (pol_pos_i),
    .hiz_i        (hiz_i),
    .pwrdn_i      (pwrdn_i),
    .cur_hi_i     (cur_hi_i),
    .up_o         (up_o),
    .dn_o         (dn_o),
    .cp_oe_o      (cp_oe_o),
    .cur_sel_o    (cur_sel_o),
    .cur_weight_o (cur_weight_o)
  );

  assign phase_err_o = req.up ^ req.dn;

  assert_gated_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hiz_i || pwrdn_i) |-> (!cp_oe_o && !up_o && !dn_o && cur_weight_o == '0));

  assert_no_both_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o && dn_o) |=> (!up_o && !dn_o) || $past(rise[CH_REF]) || $past(rise[CH_FB]));
endmodule

// File: tb/tb_pfd_cp_ctrl.sv
module tb_pfd_cp_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_s = 0, fb_s = 0, pol_s = 1, hiz_s = 0, cur_s = 1, pd_s = 0;
  logic up_w, dn_w, oe_w, cs_w, pe_w;
  logic [2:0] wt_w;

  int checks = 0, errors = 0;
  int m_pr = 0, m_pf = 0, m_up = 0, m_dn = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pfd_cp_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_s), .fb_i(fb_s),
    .pol_pos_i(pol_s), .hiz_i(hiz_s), .cur_hi_i(cur_s), .pwrdn_i(pd_s),
    .up_o(up_w), .dn_o(dn_w), .cp_oe_o(oe_w), .cur_sel_o(cs_w),
    .cur_weight_o(wt_w), .phase_err_o(pe_w)
  );

  task automatic cmp(input string tag, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic step(input bit r, input bit f, input bit p, input bit h,
                      input bit c, input bit d, input string tag);
    int act, eu, ed, ew;
    @(negedge clk);
    ref_s = r; fb_s = f; pol_s = p; hiz_s = h; cur_s = c; pd_s = d;
    #1;
    act = (!h && !d) ? 1 : 0;
    eu = act ? (p ? m_up : m_dn) : 0;
    ed = act ? (p ? m_dn : m_up) : 0;
    ew = act ? (c ? 4 : 1) : 0;
    cmp(tag, "up_o", int'(up_w), eu);
    cmp(tag, "dn_o", int'(dn_w), ed);
    cmp(tag, "cp_oe_o", int'(oe_w), act);
    cmp(tag, "cur_sel_o", int'(cs_w), act ? int'(c) : 0);
    cmp(tag, "cur_weight_o", int'(wt_w), ew);
    cmp(tag, "phase_err_o", int'(pe_w), (m_up != m_dn) ? 1 : 0);
    @(posedge clk);
    begin
      int rr = (r && !m_pr) ? 1 : 0;
      int fr = (f && !m_pf) ? 1 : 0;
      int both = (m_up && m_dn) ? 1 : 0;
      if (d) begin m_up = 0; m_dn = 0; end
      else begin
        m_up = ((m_up && !both) || rr) ? 1 : 0;
        m_dn = ((m_dn && !both) || fr) ? 1 : 0;
      end
      m_pr = r; m_pf = f;
    end
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 idle after reset
    step(0,0,1,0,1,0,"R1");
    step(0,0,1,0,1,0,"R1");
    // R2 reference leads, R3 feedback follows, R4 joint clear
    step(1,0,1,0,1,0,"R2");
    step(0,0,1,0,1,0,"R2");
    step(0,0,1,0,1,0,"R10");
    step(0,1,1,0,1,0,"R3");
    step(0,0,1,0,1,0,"R4");
    step(0,0,1,0,1,0,"R4");
    // R3 feedback leads, R5 held reference level
    step(0,1,1,0,0,0,"R3");
    step(0,0,1,0,0,0,"R3");
    for (int i = 0; i < 6; i++) step(1,0,1,0,0,0,"R5");
    step(0,0,1,0,0,0,"R5");
    // R4 simultaneous edges
    step(1,1,1,0,1,0,"R4");
    step(0,0,1,0,1,0,"R4");
    step(0,0,1,0,1,0,"R4");
    // R4 edge arrives during clearing cycle
    step(1,0,1,0,1,0,"R4");
    step(0,1,1,0,1,0,"R4");
    step(1,0,1,0,1,0,"R4");
    step(0,0,1,0,1,0,"R4");
    step(0,1,1,0,1,0,"R4");
    step(0,0,1,0,1,0,"R4");
    step(0,0,1,0,1,0,"R4");
    // R6 negative polarity swaps outputs
    step(1,0,0,0,1,0,"R6");
    step(0,0,0,0,1,0,"R6");
    step(0,1,0,0,1,0,"R6");
    step(0,0,0,0,1,0,"R6");
    step(0,1,0,0,0,0,"R6");
    step(0,0,0,0,0,0,"R6");
    step(1,0,0,0,0,0,"R6");
    step(0,0,0,0,0,0,"R6");
    // R7 high-Z gates outputs, detector keeps running (R10)
    step(1,0,1,1,1,0,"R7");
    step(0,0,1,1,1,0,"R7");
    step(0,0,1,1,0,0,"R10");
    step(0,0,1,0,1,0,"R7");
    step(0,1,1,0,1,0,"R7");
    step(0,0,1,0,1,0,"R7");
    // R8 powerdown clears held request
    step(1,0,1,0,1,0,"R8");
    step(0,0,1,0,1,0,"R8");
    step(0,0,1,0,1,1,"R8");
    step(0,0,1,0,1,1,"R8");
    step(1,0,1,0,1,1,"R8");
    step(0,0,1,0,1,1,"R8");
    step(0,0,1,0,1,0,"R8");
    step(0,1,1,0,1,0,"R8");
    step(0,0,1,0,1,0,"R8");
    step(1,0,1,0,1,0,"R8");
    step(0,0,1,0,1,0,"R8");
    // R9 current level selection
    step(0,0,1,0,0,0,"R9");
    step(0,0,1,0,1,0,"R9");
    step(0,0,0,0,0,0,"R9");
    // R2 drifting phase: periods 4 and 5 under both polarities and current levels
    for (int i = 0; i < 120; i++)
      step((i % 4) < 2, (i % 5) < 2, (i / 60) == 0, (i % 37) == 36, i[3], 0, "R2");
    for (int i = 0; i < 60; i++)
      step((i % 5) == 0, (i % 3) == 0, i[2], 0, 1, 0, "R10");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule